// File: doc/BRIEF.md
# SDRAM Command Scheduler with Refresh

This block sits between a simple request port and the command pins of one SDRAM device. A client presents one access at a time: a read/write flag, a bank, a row and a column, qualified by `req_valid` and taken when `req_ready` is also high. The scheduler opens and closes rows as needed and emits one command per clock on the chip-select, row-strobe, column-strobe and write-enable pins, together with bank and address. Each access is a single-beat burst. Moving the data itself is left to the surrounding logic.

Every analog minimum (activate-to-activate, activate-to-column, precharge, active time, row cycle) is given as a parameter in picoseconds. It is converted to whole clocks at elaboration by rounding up. Per-bank counters hold each bank back until its delays have elapsed. A free-running interval counter, derived from the number of refreshes required per retention window, raises a refresh request. The scheduler serves that request by closing every bank, waiting out the precharge, issuing an auto refresh and then holding off for a full row cycle. The same sequence runs early if any bank has stayed open close to its maximum active time. After reset the block writes the mode register once before it takes requests.

Top module: `sdram_cmd_sched`

## Requirements
- R1: The pins {cs_n, ras_n, cas_n, we_n} carry NOP=0111, ACTIVATE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, REFRESH=0001, MODE WRITE=0000. Read and write put the column on addr[COL_W-1:0] with addr[10]=0. A precharge with addr[10]=1 closes all banks, and with addr[10]=0 it closes only bank `ba`.
- R2: During reset the pins show NOP and `req_ready` is low. The first command after reset is MODE WRITE with `MODE_WORD` on addr and ba=0, and no other command follows it within T_MRD_CK clocks.
- R3: Each picosecond minimum becomes ceil(t / CLK_PS) clocks. An activate to a closed bank is followed by its column command exactly that many clocks later.
- R4: A read or write goes to an open bank only, and at least the RAS-to-CAS clock count after that bank's activate.
- R5: Activates to any two banks are at least the activate-to-activate count apart. Activates to the same bank are at least the row-cycle count apart.
- R6: A bank is activated only while closed, and at least the precharge count after its last precharge. An open bank is precharged no earlier than the active-time count after its activate.
- R7: A bank is precharged at least T_WR_CK clocks after its last write. As a result, a write and the next activate of that bank are at least T_WR_CK plus the precharge count apart.
- R8: A request to the open row issues only its column command. A request to a different row in an open bank issues PRECHARGE of that bank, then ACTIVATE, then the column command. A request to a closed bank issues ACTIVATE, then the column command.
- R9: Refreshes come at least once per interval of floor(REF_WINDOW_NS / REF_COUNT) * 1000 / CLK_PS clocks. The gap between consecutive refreshes never exceeds that interval by more than 60 clocks.
- R10: REFRESH is issued only while every bank is closed. No command follows it for the row-cycle count.
- R11: A request is taken on a clock with `req_valid` and `req_ready` both high. `req_ready` is low in the clock after a request is taken and while a refresh sequence is running.
- R12: No bank stays open longer than floor(T_RAS_MAX_PS / CLK_PS) clocks. A bank nearing that limit forces the close-and-refresh sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Scheduler can take a request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ROW_W | Row, column or mode word; bit 10 selects all banks on precharge |

## Verification
The bench builds the block with a 4000 ps clock and keeps the default nanosecond minimums, so the RAS-to-CAS and precharge counts are 5, the active time is 12 and the row cycle is 17 clocks. The refresh window is shrunk to 4,096,000 ns over 8192 refreshes, which gives a 125-clock interval, and the maximum active time is set to 280 ns, which gives 70 clocks. With these values, several refreshes and a forced close of an idle open row both occur within a few hundred clocks. A command monitor rechecks every spacing from the pins, and directed sequences cover row hit, row miss and closed-bank cases.

// File: rtl/sdram_sched_pkg.sv
// Shared types and helpers for the SDRAM command scheduler.
// Assumes single-rank, single-device command pins.
package sdram_sched_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MODE = 4'b0000,
        CMD_REF  = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_ACT  = 4'b0011,
        CMD_WR   = 4'b0100,
        CMD_RD   = 4'b0101,
        CMD_NOP  = 4'b0111
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_MODE, ST_MODE_GAP, ST_IDLE, ST_CLOSE, ST_OPEN, ST_COLUMN,
        ST_M_CLOSE, ST_M_REF, ST_M_GAP
    } sched_st_e;

    // Picoseconds to whole clocks, rounded up, never below one clock.
    function automatic int ps_to_clk(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sdram_bank_timer.sv
// Per-bank state: open flag, open row, and down-counters for the
// activate-to-column, active time, row cycle, precharge and write
// recovery minimums. A counter loaded with N-1 on a command lets the
// next dependent command appear on the pins N clocks later.
// Assumes the caller only issues commands when the *_ok outputs allow.
module sdram_bank_timer #(
    parameter int ROW_W    = 13,
    parameter int CW       = 6,
    parameter int T_RCD_CK = 3,
    parameter int T_RAS_CK = 6,
    parameter int T_RC_CK  = 9,
    parameter int T_RP_CK  = 3,
    parameter int T_WR_CK  = 2,
    parameter int AGE_LIM  = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             col_i,
    input  logic             wr_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             act_ok_o,
    output logic             col_ok_o,
    output logic             pre_ok_o,
    output logic             age_hi_o
);
    localparam int AW = $clog2(AGE_LIM + 1);

    logic [CW-1:0] rcd_q, ras_q, rc_q, rp_q, wr_q;
    logic [AW-1:0] age_q;
    logic          open_q;
    logic [ROW_W-1:0] row_q;

    function automatic logic [CW-1:0] step(input logic ld, input logic [CW-1:0] cur, input int n);
        if (ld) return CW'(n - 1);
        if (cur != '0) return cur - CW'(1);
        return cur;
    endfunction

    // Timing counters: reload on the governing command, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcd_q <= '0; ras_q <= '0; rc_q <= '0; rp_q <= '0; wr_q <= '0;
        end else begin
            rcd_q <= step(act_i, rcd_q, T_RCD_CK);
            ras_q <= step(act_i, ras_q, T_RAS_CK);
            rc_q  <= step(act_i, rc_q,  T_RC_CK);
            rp_q  <= step(pre_i, rp_q,  T_RP_CK);
            wr_q  <= step(wr_i,  wr_q,  T_WR_CK);
        end
    end

    // Open row tracking and saturating open-age counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0; row_q <= '0; age_q <= '0;
        end else if (act_i) begin
            open_q <= 1'b1; row_q <= row_i; age_q <= '0;
        end else if (pre_i) begin
            open_q <= 1'b0; age_q <= '0;
        end else if (open_q && age_q != AW'(AGE_LIM)) begin
            age_q <= age_q + AW'(1);
        end
    end

    assign open_o   = open_q;
    assign row_o    = row_q;
    assign act_ok_o = !open_q && rp_q == '0 && rc_q == '0;
    assign col_ok_o = open_q && rcd_q == '0;
    assign pre_ok_o = ras_q == '0 && wr_q == '0;
    assign age_hi_o = open_q && age_q >= AW'(AGE_LIM);

    AST_COL_AFTER_RCD: assert property (@(posedge clk) disable iff (!rst_n)
        col_i |-> (open_q && rcd_q == '0)); // R4
    AST_ACT_WHEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |-> (!open_q && rp_q == '0 && rc_q == '0)); // R6
    AST_PRE_AFTER_RAS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_i && open_q) |-> (ras_q == '0 && wr_q == '0)); // R7
endmodule

// File: rtl/sdram_refresh_timer.sv
// Free-running refresh interval counter. Raises due_o every IV clocks
// and holds it until the scheduler reports a refresh issued.
// Assumes IV is larger than the longest close-and-refresh sequence.
module sdram_refresh_timer #(
    parameter int IV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_done_i,
    output logic due_o
);
    localparam int IW = $clog2(IV + 1);

    logic [IW-1:0] cnt_q;
    logic          pend_q;
    logic          tick;

    assign tick = cnt_q == IW'(IV - 1);

    // Interval counter and pending flag; a new tick wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0; pend_q <= 1'b0;
        end else begin
            cnt_q <= tick ? '0 : cnt_q + IW'(1);
            if (tick) pend_q <= 1'b1;
            else if (ref_done_i) pend_q <= 1'b0;
        end
    end

    assign due_o = pend_q;

    AST_NO_MISSED_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !pend_q); // R9
endmodule

// File: rtl/sdram_cmd_sched.sv
// SDRAM command scheduler. Takes one single-beat access at a time,
// opens/closes rows as required, enforces per-bank and cross-bank
// minimum spacings, and runs a close-all / refresh sequence when the
// refresh interval expires or a bank nears its maximum active time.
// Assumes NUM_BANKS is a power of two, ROW_W > 10 and COL_W <= 10,
// and that the device is already powered up and precharged at reset.
module sdram_cmd_sched
    import sdram_sched_pkg::*;
#(
    parameter int NUM_BANKS     = 4,
    parameter int ROW_W         = 13,
    parameter int COL_W         = 9,
    parameter int CLK_PS        = 7500,
    parameter int T_RRD_PS      = 15000,
    parameter int T_RCD_PS      = 19000,
    parameter int T_RP_PS       = 19000,
    parameter int T_RAS_PS      = 45000,
    parameter int T_RC_PS       = 65000,
    parameter int T_RAS_MAX_PS  = 100_000_000,
    parameter int T_WR_CK       = 2,
    parameter int T_MRD_CK      = 2,
    parameter int REF_WINDOW_NS = 64_000_000,
    parameter int REF_COUNT     = 8192,
    parameter logic [ROW_W-1:0] MODE_WORD = 'h020
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
    input  logic [ROW_W-1:0]     req_row,
    input  logic [COL_W-1:0]     req_col,
    output logic                 cs_n,
    output logic                 ras_n,
    output logic                 cas_n,
    output logic                 we_n,
    output logic [$clog2(NUM_BANKS)-1:0] ba,
    output logic [ROW_W-1:0]     addr
);
    localparam int BA_W       = $clog2(NUM_BANKS);
    localparam int RRD_CK     = ps_to_clk(T_RRD_PS, CLK_PS);
    localparam int RCD_CK     = ps_to_clk(T_RCD_PS, CLK_PS);
    localparam int RP_CK      = ps_to_clk(T_RP_PS, CLK_PS);
    localparam int RAS_CK     = ps_to_clk(T_RAS_PS, CLK_PS);
    localparam int RC_CK      = ps_to_clk(T_RC_PS, CLK_PS);
    localparam int RAS_MAX_CK = T_RAS_MAX_PS / CLK_PS;
    localparam int REF_IV     = (REF_WINDOW_NS / REF_COUNT) * 1000 / CLK_PS;
    localparam int MARGIN     = RAS_CK + RP_CK + RCD_CK + T_WR_CK + 4;
    localparam int AGE_LIM    = RAS_MAX_CK - MARGIN;
    localparam int CW         = $clog2(RC_CK + RAS_CK + RRD_CK + T_WR_CK + T_MRD_CK + 1);

    sched_st_e        state_q, state_d;
    sd_cmd_e          cmd_q, cmd_d;
    logic [BA_W-1:0]  ba_q, ba_d, q_bank;
    logic [ROW_W-1:0] addr_q, addr_d, q_row;
    logic [COL_W-1:0] q_col;
    logic             q_write, accept;
    logic [CW-1:0]    gap_q, gap_val, rrd_q;
    logic             gap_ld, rrd_ld, col_v, wr_v, ref_v, ref_due, maint_due;
    logic [NUM_BANKS-1:0] act_v, pre_v;
    logic [NUM_BANKS-1:0] bk_open, bk_act_ok, bk_col_ok, bk_pre_ok, bk_age_hi;
    logic [ROW_W-1:0]     bk_row [NUM_BANKS];

    // One timer per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_timer #(
            .ROW_W(ROW_W), .CW(CW), .T_RCD_CK(RCD_CK), .T_RAS_CK(RAS_CK),
            .T_RC_CK(RC_CK), .T_RP_CK(RP_CK), .T_WR_CK(T_WR_CK), .AGE_LIM(AGE_LIM)
        ) i_bank (
            .clk(clk), .rst_n(rst_n), .act_i(act_v[b]), .pre_i(pre_v[b]),
            .col_i(col_v && q_bank == BA_W'(b)), .wr_i(wr_v && q_bank == BA_W'(b)),
            .row_i(q_row), .open_o(bk_open[b]), .row_o(bk_row[b]),
            .act_ok_o(bk_act_ok[b]), .col_ok_o(bk_col_ok[b]),
            .pre_ok_o(bk_pre_ok[b]), .age_hi_o(bk_age_hi[b])
        );
    end

    sdram_refresh_timer #(.IV(REF_IV)) i_refresh (
        .clk(clk), .rst_n(rst_n), .ref_done_i(ref_v), .due_o(ref_due)
    );

    assign maint_due = ref_due || (|bk_age_hi);
    assign req_ready = (state_q == ST_IDLE) && !maint_due;

    // Next command and state selection.
    always_comb begin
        state_d = state_q; cmd_d = CMD_NOP; ba_d = '0; addr_d = '0;
        act_v = '0; pre_v = '0; col_v = 1'b0; wr_v = 1'b0; ref_v = 1'b0;
        accept = 1'b0; gap_ld = 1'b0; gap_val = '0; rrd_ld = 1'b0;
        case (state_q)
            ST_MODE: begin
                cmd_d = CMD_MODE; addr_d = MODE_WORD;
                gap_ld = 1'b1; gap_val = CW'(T_MRD_CK - 1); state_d = ST_MODE_GAP;
            end
            ST_MODE_GAP: if (gap_q == '0) state_d = ST_IDLE;
            ST_IDLE: begin
                if (maint_due) state_d = ST_M_CLOSE;
                else if (req_valid) begin
                    accept = 1'b1;
                    if (!bk_open[req_bank]) state_d = ST_OPEN;
                    else if (bk_row[req_bank] == req_row) state_d = ST_COLUMN;
                    else state_d = ST_CLOSE;
                end
            end
            ST_CLOSE: if (bk_pre_ok[q_bank]) begin
                cmd_d = CMD_PRE; ba_d = q_bank; pre_v[q_bank] = 1'b1; state_d = ST_OPEN;
            end
            ST_OPEN: if (bk_act_ok[q_bank] && rrd_q == '0) begin
                cmd_d = CMD_ACT; ba_d = q_bank; addr_d = q_row;
                act_v[q_bank] = 1'b1; rrd_ld = 1'b1; state_d = ST_COLUMN;
            end
            ST_COLUMN: if (bk_col_ok[q_bank]) begin
                cmd_d = q_write ? CMD_WR : CMD_RD; ba_d = q_bank;
                addr_d = ROW_W'(q_col); col_v = 1'b1; wr_v = q_write; state_d = ST_IDLE;
            end
            ST_M_CLOSE: if (&(bk_pre_ok | ~bk_open)) begin
                cmd_d = CMD_PRE; addr_d[10] = 1'b1; pre_v = '1; state_d = ST_M_REF;
            end
            ST_M_REF: if (&bk_act_ok) begin
                cmd_d = CMD_REF; ref_v = 1'b1;
                gap_ld = 1'b1; gap_val = CW'(RC_CK - 1); state_d = ST_M_GAP;
            end
            ST_M_GAP: if (gap_q == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State, registered pins, latched request and global gap counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_MODE; cmd_q <= CMD_NOP; ba_q <= '0; addr_q <= '0;
            q_bank <= '0; q_row <= '0; q_col <= '0; q_write <= 1'b0;
            gap_q <= '0; rrd_q <= '0;
        end else begin
            state_q <= state_d; cmd_q <= cmd_d; ba_q <= ba_d; addr_q <= addr_d;
            if (accept) begin
                q_bank <= req_bank; q_row <= req_row; q_col <= req_col; q_write <= req_write;
            end
            if (gap_ld) gap_q <= gap_val;
            else if (gap_q != '0) gap_q <= gap_q - CW'(1);
            if (rrd_ld) rrd_q <= CW'(RRD_CK - 1);
            else if (rrd_q != '0) rrd_q <= rrd_q - CW'(1);
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
    assign ba   = ba_q;
    assign addr = addr_q;

    AST_REF_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_REF) |-> (bk_open == '0)); // R10
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R11
    AST_ONE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_v)); // R5
endmodule

// File: tb/test_sdram_cmd_sched.sv
`timescale 1ns/1ps
module test_sdram_cmd_sched;
    localparam int CLK_PS = 4000;
    localparam int RRD_PS = 15000, RCD_PS = 19000, RP_PS = 19000;
    localparam int RAS_PS = 45000, RC_PS = 65000, RASMAX_PS = 280_000;
    localparam int WR_CK = 2, MRD_CK = 2;
    localparam int WIN_NS = 4_096_000, NREF = 8192;
    localparam logic [12:0] MODE = 13'h020;

    function automatic int cclk(input int t);
        return (t + CLK_PS - 1) / CLK_PS;
    endfunction
    localparam int RRD = cclk(RRD_PS), RCD = cclk(RCD_PS), RP = cclk(RP_PS);
    localparam int RAS = cclk(RAS_PS), RC = cclk(RC_PS);
    localparam int RASMAX = RASMAX_PS / CLK_PS;
    localparam int REFIV = (WIN_NS / NREF) * 1000 / CLK_PS;

    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                           C_MODE = 4'b0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_bank = '0;
    logic [12:0] req_row = '0;
    logic [8:0] req_col = '0;
    logic req_ready, cs_n, ras_n, cas_n, we_n;
    logic [1:0] ba;
    logic [12:0] addr;

    always #2 clk = ~clk;

    sdram_cmd_sched #(
        .CLK_PS(CLK_PS), .T_RRD_PS(RRD_PS), .T_RCD_PS(RCD_PS), .T_RP_PS(RP_PS),
        .T_RAS_PS(RAS_PS), .T_RC_PS(RC_PS), .T_RAS_MAX_PS(RASMAX_PS),
        .T_WR_CK(WR_CK), .T_MRD_CK(MRD_CK), .REF_WINDOW_NS(WIN_NS),
        .REF_COUNT(NREF), .MODE_WORD(MODE)
    ) i_sdram_cmd_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr)
    );

    int total = 0, bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- command monitor ----------------
    int cyc = 0;
    int t_act[4], t_pre[4], t_wr[4];
    bit opn[4];
    int t_any_act, t_ref, t_mode, ref_cnt = 0, mode_cnt = 0;
    bit ref_seen;
    int lg_cmd[64], lg_ba[64], lg_addr[64], lg_t[64];
    int lg_n = 0;

    always @(negedge clk) begin
        logic [3:0] c;
        c = {cs_n, ras_n, cas_n, we_n};
        cyc++;
        if (!rst_n) begin
            for (int b = 0; b < 4; b++) begin
                t_act[b] = -100000; t_pre[b] = -100000; t_wr[b] = -100000; opn[b] = 0;
            end
            t_any_act = -100000; t_ref = -100000; t_mode = -100000; ref_seen = 0;
        end else if (c != C_NOP) begin
            chk(cyc - t_mode >= MRD_CK, "R2 gap after mode write", cyc - t_mode, MRD_CK);
            chk(cyc - t_ref >= RC, "R10 gap after refresh", cyc - t_ref, RC);
            if (c == C_ACT) begin
                chk(!opn[int'(ba)], "R6 activate of closed bank", int'(opn[int'(ba)]), 0);
                chk(cyc - t_pre[int'(ba)] >= RP, "R6 precharge to activate", cyc - t_pre[int'(ba)], RP);
                chk(cyc - t_act[int'(ba)] >= RC, "R5 same-bank row cycle", cyc - t_act[int'(ba)], RC);
                chk(cyc - t_any_act >= RRD, "R5 activate to activate", cyc - t_any_act, RRD);
                chk(cyc - t_wr[int'(ba)] >= WR_CK + RP, "R7 write to activate", cyc - t_wr[int'(ba)], WR_CK + RP);
                opn[int'(ba)] = 1; t_act[int'(ba)] = cyc; t_any_act = cyc;
            end
            if (c == C_RD || c == C_WR) begin
                chk(opn[int'(ba)], "R4 column to open bank", int'(opn[int'(ba)]), 1);
                chk(cyc - t_act[int'(ba)] >= RCD, "R4 activate to column", cyc - t_act[int'(ba)], RCD);
                chk(addr[10] == 1'b0, "R1 column bit 10 low", int'(addr[10]), 0);
                if (c == C_WR) t_wr[int'(ba)] = cyc;
            end
            if (c == C_PRE) begin
                for (int b = 0; b < 4; b++) begin
                    if (addr[10] || int'(ba) == b) begin
                        if (opn[b]) begin
                            chk(cyc - t_act[b] >= RAS, "R6 active time", cyc - t_act[b], RAS);
                            chk(cyc - t_wr[b] >= WR_CK, "R7 write recovery", cyc - t_wr[b], WR_CK);
                            chk(cyc - t_act[b] <= RASMAX, "R12 max active time", cyc - t_act[b], RASMAX);
                        end
                        opn[b] = 0; t_pre[b] = cyc;
                    end
                end
            end
            if (c == C_REF) begin
                chk(!(opn[0] | opn[1] | opn[2] | opn[3]), "R10 refresh with banks closed", 1, 0);
                chk(!req_ready, "R11 ready low during refresh", int'(req_ready), 0);
                if (ref_seen)
                    chk(cyc - t_ref <= REFIV + 60, "R9 refresh spacing", cyc - t_ref, REFIV + 60);
                ref_seen = 1; t_ref = cyc; ref_cnt++;
            end
            if (c == C_MODE) begin
                chk(addr == MODE && ba == 2'd0, "R2 mode word", int'(addr), int'(MODE));
                t_mode = cyc; mode_cnt++;
            end
            if ((c == C_ACT || c == C_RD || c == C_WR || (c == C_PRE && !addr[10])) && lg_n < 64) begin
                lg_cmd[lg_n] = int'(c); lg_ba[lg_n] = int'(ba);
                lg_addr[lg_n] = int'(addr); lg_t[lg_n] = cyc; lg_n++;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic send(input logic w, input logic [1:0] b, input logic [12:0] row, input logic [8:0] col);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_bank = b; req_row = row; req_col = col;
        n = 0;
        while (!req_ready && n < 500) begin @(negedge clk); n++; end
        chk(n < 500, "R11 request taken", n, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R11 ready low after accept", int'(req_ready), 0);
    endtask

    task automatic wait_log(input int n);
        int k = 0;
        while (lg_n < n && k < 300) begin @(negedge clk); k++; end
        chk(lg_n >= n, "R8 expected commands appear", lg_n, n);
    endtask

    task automatic wait_quiet();
        int n0 = ref_cnt;
        int k = 0;
        while (ref_cnt == n0 && k < 400) begin @(negedge clk); k++; end
        repeat (RC + 2) @(negedge clk);
    endtask

    task automatic chk_log(input int i, input logic [3:0] c, input int b, input int a, input string tag);
        chk(lg_cmd[i] == int'(c), {tag, " command"}, lg_cmd[i], int'(c));
        chk(lg_ba[i] == b, {tag, " bank"}, lg_ba[i], b);
        chk(lg_addr[i] == a, {tag, " address"}, lg_addr[i], a);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        int k = 0;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R2 NOP in reset", int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
        chk(!req_ready, "R2 ready low in reset", int'(req_ready), 0);
        @(posedge clk); rst_n <= 1'b1;
        while (mode_cnt == 0 && k < 10) begin @(negedge clk); k++; end
        chk(mode_cnt == 1, "R2 first command is mode write", mode_cnt, 1);
        chk(ref_cnt == 0 && lg_n == 0, "R2 nothing before mode write", lg_n, 0);
    endtask

    task automatic t_access();
        wait_quiet();
        lg_n = 0;
        send(1'b1, 2'd0, 13'd5, 9'd3);
        wait_log(2);
        chk_log(0, C_ACT, 0, 5, "R8 closed bank activate");
        chk_log(1, C_WR, 0, 3, "R8 closed bank write");
        chk(lg_t[1] - lg_t[0] == RCD, "R3 activate to column exact", lg_t[1] - lg_t[0], RCD);
        send(1'b0, 2'd0, 13'd5, 9'd7);
        wait_log(3);
        chk_log(2, C_RD, 0, 7, "R8 row hit read");
        send(1'b0, 2'd0, 13'd9, 9'd2);
        wait_log(6);
        chk_log(3, C_PRE, 0, 0, "R8 miss precharge");
        chk_log(4, C_ACT, 0, 9, "R8 miss activate");
        chk_log(5, C_RD, 0, 2, "R8 miss read");
        chk(lg_t[5] - lg_t[4] == RCD, "R3 miss activate to column", lg_t[5] - lg_t[4], RCD);
        send(1'b1, 2'd1, 13'd4, 9'd1);
        wait_log(8);
        chk_log(6, C_ACT, 1, 4, "R5 second bank activate");
        chk_log(7, C_WR, 1, 1, "R8 second bank write");
        send(1'b1, 2'd1, 13'd4, 9'd8);
        send(1'b0, 2'd1, 13'd6, 9'd0);
        wait_log(12);
        chk_log(9, C_PRE, 1, 0, "R7 precharge after write");
        chk_log(11, C_RD, 1, 0, "R8 read after write miss");
    endtask

    task automatic t_refresh();
        int n0 = ref_cnt;
        int k = 0;
        while (ref_cnt < n0 + 3 && k < 3 * (REFIV + 60)) begin @(negedge clk); k++; end
        chk(ref_cnt >= n0 + 3, "R9 refreshes keep coming", ref_cnt - n0, 3);
    endtask

    task automatic t_rasmax();
        int ta;
        wait_quiet();
        lg_n = 0;
        send(1'b0, 2'd2, 13'd11, 9'd0);
        wait_log(2);
        ta = t_act[2];
        while (cyc < ta + RASMAX) @(negedge clk);
        chk(!opn[2], "R12 idle row closed in time", int'(opn[2]), 0);
        chk(t_pre[2] > ta, "R12 forced precharge seen", t_pre[2], ta + 1);
    endtask

    initial begin
        t_reset();
        t_access();
        t_refresh();
        t_rasmax();
        repeat (20) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule